// File: doc/BRIEF.md
# Crate Timing and Stimulus Controller

This block drives the timing lines of a crate of digitizer boards and stands in for the trigger system when the crate is tested. It runs in one of four modes held in a two-bit mode register. In trigger-follow mode it forwards an external level-one accept strobe and its reset line, retimed by one clock. In calibration mode it runs a fixed sequence on its own. First it shifts a 16-bit level into the calibration DAC over a serial clock/data pair with a frame select. It then waits a settling time, raises a test pulse and counts a programmed delay. Last, it issues a one-cycle accept strobe. In free-run mode it keeps every trigger, pulse and serial line quiet, so only the crate clock runs. In gain-trim mode it shifts a word out to the digital potentiometers that set the channel gains.

The sequencer is a single state machine with states `SQ_IDLE`, `SQ_DAC`, `SQ_SETTLE`, `SQ_PULSE`, `SQ_DELAY`, `SQ_L1` and `SQ_GAIN`. It has these transitions:
- `SQ_IDLE` to `SQ_DAC` on an accepted calibration start.
- `SQ_IDLE` to `SQ_GAIN` on an accepted gain start.
- `SQ_DAC` to `SQ_SETTLE` on the last serial cycle.
- `SQ_SETTLE` to `SQ_PULSE` after the settle count.
- `SQ_PULSE` to `SQ_DELAY` after the pulse count when the delay is non-zero, or to `SQ_L1` when it is zero.
- `SQ_DELAY` to `SQ_L1` when the delay count expires.
- `SQ_L1` to `SQ_IDLE` after one cycle.
- `SQ_GAIN` to `SQ_IDLE` on the last serial cycle.

The serial clock is the system clock divided by four. A mode write that arrives during a sequence is held and applied once the sequencer is idle.

Top module: `tctl_top`

## Requirements
- R1: While reset is asserted, the mode reads 0 (trigger-follow). Both accept lines, the test pulse, the serial clock and busy are low, and both frame selects are high.
- R2: Mode codes are 0 trigger-follow, 1 calibration, 2 free-run and 3 gain-trim. When the sequencer is idle, a mode write appears on `mode_q` in the cycle after the write edge.
- R3: In trigger-follow mode, `crate_l1` and `crate_l1_rst` equal `ext_l1` and `ext_l1_rst` as sampled on the previous clock edge.
- R4: A calibration start shifts the 16-bit `cal_dac_code` out MSB first on `ser_dat`. `ser_clk` is low for 2 cycles and high for 2 cycles, and its first rise is in the third cycle after the start edge. Data is stable while `ser_clk` is high. `dac_cs_n` is low for exactly 64 cycles, and the two frame selects are never low together.
- R5: Sixteen cycles after `dac_cs_n` returns high, `test_pulse` goes high for exactly 4 cycles. Its first high cycle is the 81st cycle after the start edge.
- R6: In calibration, `crate_l1` is high for exactly one cycle, D+4 cycles after the rise of `test_pulse`. D is the `cal_delay` captured at start, and D = 0 is allowed.
- R7: A gain start in gain-trim mode shifts the POT_W-bit `gain_word` (8 bits by default) MSB first with the same serial timing. `pot_cs_n` is low for exactly 4*POT_W cycles.
- R8: `busy` is high from the cycle after an accepted start through the last cycle of the sequence. That is 85+D cycles for calibration and 4*POT_W cycles for gain-trim.
- R9: A mode write during a sequence leaves `mode_q` unchanged while busy. The last such write takes effect one cycle after `busy` falls.
- R10: A start that does not match the current mode is ignored, and so is a calibration start while busy. Neither changes any serial line, busy or the running sequence timing.
- R11: In free-run mode, starts and external trigger inputs produce no accept, reset, test pulse, frame select or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code to write |
| cal_start | input | 1 | Start calibration sequence |
| cal_dac_code | input | 16 | DAC level for calibration |
| cal_delay | input | DLY_W | Pulse-to-accept extra delay D |
| gain_start | input | 1 | Start a potentiometer load |
| gain_word | input | POT_W | Potentiometer word |
| ext_l1 | input | 1 | External accept strobe |
| ext_l1_rst | input | 1 | External accept reset |
| mode_q | output | 2 | Active mode |
| crate_l1 | output | 1 | Accept strobe to the crate |
| crate_l1_rst | output | 1 | Accept reset to the crate |
| test_pulse | output | 1 | Test pulse trigger to the pulser |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |
| dac_cs_n | output | 1 | DAC frame select, active low |
| pot_cs_n | output | 1 | Potentiometer frame select, active low |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest case to reach is a deferred mode change. A write must land while a calibration sequence is in progress, a second write must override it, and the bench must then see exactly when the held value takes hold after `busy` falls. The bench starts a calibration and issues two writes at fixed cycle offsets inside the sequence. It then samples `mode_q` in the first idle cycle and in the cycle after it. Pulse and accept timing is swept over every delay from 0 to 16 and over 255, and the potentiometer word over all 256 values.

// File: rtl/tctl_pkg.sv
package tctl_pkg;
    typedef enum logic [1:0] {
        MODE_COLL = 2'd0,
        MODE_CAL  = 2'd1,
        MODE_INT  = 2'd2,
        MODE_GAIN = 2'd3
    } tmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DAC,
        SQ_SETTLE,
        SQ_PULSE,
        SQ_DELAY,
        SQ_L1,
        SQ_GAIN
    } sq_state_e;
endpackage

// File: rtl/tctl_mode_reg.sv
module tctl_mode_reg
    import tctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_wr,
    input  tmode_e mode_wdata,
    input  logic   can_switch,
    output tmode_e mode_q
);
    tmode_e pend_mode_q;
    logic   pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_COLL;
            pend_mode_q <= MODE_COLL;
            pend_q      <= 1'b0;
        end else if (mode_wr) begin
            if (can_switch) begin
                mode_q <= mode_wdata;
                pend_q <= 1'b0;
            end else begin
                pend_mode_q <= mode_wdata;
                pend_q      <= 1'b1;
            end
        end else if (pend_q && can_switch) begin
            mode_q <= pend_mode_q;
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tctl_shifter.sv
module tctl_shifter #(
    parameter int MAXW      = 16,
    parameter int SCLK_DIV  = 4,
    localparam int LEN_W    = $clog2(MAXW + 1),
    localparam int PH_W     = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAXW-1:0]  word,
    input  logic [LEN_W-1:0] len,
    output logic             sclk,
    output logic             sdat,
    output logic             last
);
    logic [MAXW-1:0]  sh_q;
    logic [LEN_W-1:0] left_q;
    logic [PH_W-1:0]  ph_q;
    logic             act_q;
    logic             ph_end;

    assign ph_end = (ph_q == PH_W'(SCLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            ph_q   <= '0;
            act_q  <= 1'b0;
        end else if (start && !act_q) begin
            sh_q   <= word;
            left_q <= len;
            ph_q   <= '0;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (ph_end) begin
                ph_q <= '0;
                if (left_q == LEN_W'(1)) begin
                    act_q <= 1'b0;
                    sh_q  <= '0;
                end else begin
                    left_q <= left_q - LEN_W'(1);
                    sh_q   <= {sh_q[MAXW-2:0], 1'b0};
                end
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    always_comb begin
        sclk = act_q && (ph_q >= PH_W'(SCLK_DIV / 2));
        sdat = act_q && sh_q[MAXW-1];
        last = act_q && ph_end && (left_q == LEN_W'(1));
    end
endmodule

// File: rtl/tctl_seq.sv
module tctl_seq
    import tctl_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int PULSE_CYC  = 4,
    parameter int DLY_W      = 8,
    localparam int MAXC      = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC,
    localparam int CW1       = $clog2(MAXC + 1),
    localparam int CNT_W     = (DLY_W > CW1) ? DLY_W : CW1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmode_e           mode_q,
    input  logic             cal_start,
    input  logic             gain_start,
    input  logic [DLY_W-1:0] cal_delay,
    input  logic             shift_last,
    output logic             shift_start,
    output logic             shift_pot,
    output logic             dac_sel,
    output logic             pot_sel,
    output logic             test_pulse,
    output logic             cal_l1,
    output logic             busy,
    output logic             can_switch
);
    sq_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q;
    logic             cal_go, gain_go;

    assign cal_go  = (state_q == SQ_IDLE) && cal_start  && (mode_q == MODE_CAL);
    assign gain_go = (state_q == SQ_IDLE) && gain_start && (mode_q == MODE_GAIN);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (cal_go)       state_d = SQ_DAC;
                else if (gain_go) state_d = SQ_GAIN;
            end
            SQ_DAC:    if (shift_last) state_d = SQ_SETTLE;
            SQ_SETTLE: if (cnt_q == CNT_W'(SETTLE_CYC - 1)) state_d = SQ_PULSE;
            SQ_PULSE: begin
                if (cnt_q == CNT_W'(PULSE_CYC - 1))
                    state_d = (dly_q == '0) ? SQ_L1 : SQ_DELAY;
            end
            SQ_DELAY:  if (cnt_q == CNT_W'(dly_q) - CNT_W'(1)) state_d = SQ_L1;
            SQ_L1:     state_d = SQ_IDLE;
            SQ_GAIN:   if (shift_last) state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // state register with dwell counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
            if (cal_go) dly_q <= cal_delay;
        end
    end

    // outputs decoded from state
    always_comb begin
        dac_sel    = 1'b0;
        pot_sel    = 1'b0;
        test_pulse = 1'b0;
        cal_l1     = 1'b0;
        unique case (state_q)
            SQ_IDLE:   ;
            SQ_DAC:    dac_sel    = 1'b1;
            SQ_SETTLE: ;
            SQ_PULSE:  test_pulse = 1'b1;
            SQ_DELAY:  ;
            SQ_L1:     cal_l1     = 1'b1;
            SQ_GAIN:   pot_sel    = 1'b1;
            default:   ;
        endcase
        busy        = (state_q != SQ_IDLE);
        shift_start = cal_go || gain_go;
        shift_pot   = gain_go;
        can_switch  = (state_q == SQ_IDLE) && !shift_start;
    end
endmodule

// File: rtl/tctl_top.sv
module tctl_top
    import tctl_pkg::*;
#(
    parameter int DAC_W      = 16,
    parameter int POT_W      = 8,
    parameter int DLY_W      = 8,
    parameter int SCLK_DIV   = 4,
    parameter int SETTLE_CYC = 16,
    parameter int PULSE_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             cal_start,
    input  logic [DAC_W-1:0] cal_dac_code,
    input  logic [DLY_W-1:0] cal_delay,
    input  logic             gain_start,
    input  logic [POT_W-1:0] gain_word,
    input  logic             ext_l1,
    input  logic             ext_l1_rst,
    output logic [1:0]       mode_q,
    output logic             crate_l1,
    output logic             crate_l1_rst,
    output logic             test_pulse,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             dac_cs_n,
    output logic             pot_cs_n,
    output logic             busy
);
    localparam int MAXW  = (DAC_W > POT_W) ? DAC_W : POT_W;
    localparam int LEN_W = $clog2(MAXW + 1);

    tmode_e          mode_e;
    logic            can_switch, shift_start, shift_pot, shift_last;
    logic            dac_sel, pot_sel, cal_l1;
    logic [MAXW-1:0] dac_al, pot_al, sh_word;
    logic [LEN_W-1:0] sh_len;
    logic            coll_l1_q, coll_rst_q;

    tctl_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (tmode_e'(mode_wdata)),
        .can_switch (can_switch),
        .mode_q     (mode_e)
    );

    tctl_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .DLY_W      (DLY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_e),
        .cal_start   (cal_start),
        .gain_start  (gain_start),
        .cal_delay   (cal_delay),
        .shift_last  (shift_last),
        .shift_start (shift_start),
        .shift_pot   (shift_pot),
        .dac_sel     (dac_sel),
        .pot_sel     (pot_sel),
        .test_pulse  (test_pulse),
        .cal_l1      (cal_l1),
        .busy        (busy),
        .can_switch  (can_switch)
    );

    // left-align both words so the shifter always emits from its top bit
    always_comb begin
        dac_al  = MAXW'(cal_dac_code) << (MAXW - DAC_W);
        pot_al  = MAXW'(gain_word) << (MAXW - POT_W);
        sh_word = shift_pot ? pot_al : dac_al;
        sh_len  = shift_pot ? LEN_W'(POT_W) : LEN_W'(DAC_W);
    end

    tctl_shifter #(
        .MAXW     (MAXW),
        .SCLK_DIV (SCLK_DIV)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (shift_start),
        .word  (sh_word),
        .len   (sh_len),
        .sclk  (ser_clk),
        .sdat  (ser_dat),
        .last  (shift_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_l1_q  <= 1'b0;
            coll_rst_q <= 1'b0;
        end else begin
            coll_l1_q  <= ext_l1;
            coll_rst_q <= ext_l1_rst;
        end
    end

    always_comb begin
        mode_q       = mode_e;
        crate_l1     = ((mode_e == MODE_COLL) && coll_l1_q) || cal_l1;
        crate_l1_rst = (mode_e == MODE_COLL) && coll_rst_q;
        dac_cs_n     = !dac_sel;
        pot_cs_n     = !pot_sel;
    end
endmodule

// File: rtl/tctl_checker.sv
module tctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_q,
    input logic       busy,
    input logic       test_pulse,
    input logic       crate_l1,
    input logic       ext_l1,
    input logic       dac_cs_n,
    input logic       pot_cs_n,
    input logic       ser_clk
);
    p_cs_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dac_cs_n && !pot_cs_n));

    p_sclk_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (!dac_cs_n || !pot_cs_n));

    p_pulse_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_pulse |-> (mode_q == 2'd1));

    p_l1_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (crate_l1 && mode_q == 2'd1) |=> !crate_l1);

    p_frame_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n || !pot_cs_n) |-> busy);

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(mode_q));

    p_coll_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == 2'd0 && $past(mode_q) == 2'd0) |-> (crate_l1 == $past(ext_l1)));

    p_quiet_int_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2) |-> (!crate_l1 && !test_pulse && dac_cs_n && pot_cs_n));
endmodule

bind tctl_top tctl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .busy       (busy),
    .test_pulse (test_pulse),
    .crate_l1   (crate_l1),
    .ext_l1     (ext_l1),
    .dac_cs_n   (dac_cs_n),
    .pot_cs_n   (pot_cs_n),
    .ser_clk    (ser_clk)
);

// File: tb/sim_tctl_top.sv
module sim_tctl_top;
    localparam int DAC_W = 16;
    localparam int POT_W = 8;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [1:0]       mode_wdata = '0;
    logic             cal_start = 1'b0;
    logic [DAC_W-1:0] cal_dac_code = '0;
    logic [DLY_W-1:0] cal_delay = '0;
    logic             gain_start = 1'b0;
    logic [POT_W-1:0] gain_word = '0;
    logic             ext_l1 = 1'b0;
    logic             ext_l1_rst = 1'b0;
    logic [1:0]       mode_q;
    logic             crate_l1, crate_l1_rst, test_pulse, ser_clk, ser_dat;
    logic             dac_cs_n, pot_cs_n, busy;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    tctl_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cal_start(cal_start), .cal_dac_code(cal_dac_code), .cal_delay(cal_delay),
        .gain_start(gain_start), .gain_word(gain_word), .ext_l1(ext_l1),
        .ext_l1_rst(ext_l1_rst), .mode_q(mode_q), .crate_l1(crate_l1),
        .crate_l1_rst(crate_l1_rst), .test_pulse(test_pulse), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .dac_cs_n(dac_cs_n), .pot_cs_n(pot_cs_n), .busy(busy)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_wr = 1'b1;
        mode_wdata = m;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic run_cal(logic [15:0] code, int d, bit poke);
        int cs_len = 0, rises = 0, first_rise = -1, prise = -1, plen = 0;
        int l1c = -1, l1n = 0, blen = 0;
        logic [15:0] got = '0;
        logic psclk = 1'b0;
        cal_delay = DLY_W'(d);
        cal_dac_code = code;
        cal_start = 1'b1;
        step();
        cal_start = 1'b0;
        for (int k = 1; k < 400; k++) begin
            if (!busy) break;
            blen++;
            if (!dac_cs_n) cs_len++;
            if (ser_clk && !psclk) begin
                rises++;
                got = {got[14:0], ser_dat};
                if (first_rise < 0) first_rise = k;
            end
            psclk = ser_clk;
            if (test_pulse) begin
                plen++;
                if (prise < 0) prise = k;
            end
            if (crate_l1) begin
                l1n++;
                l1c = k;
            end
            cal_start = (poke && k == 50);
            step();
        end
        cal_start = 1'b0;
        check("R4 dac frame length", cs_len, 64);
        check("R4 sclk rises", rises, 16);
        check("R4 first sclk rise", first_rise, 3);
        check("R4 dac word", got, code);
        check("R5 pulse start", prise, 81);
        check("R5 pulse length", plen, 4);
        check("R6 l1 cycle", l1c, 85 + d);
        check("R6 l1 count", l1n, 1);
        check("R8 cal busy length", blen, 85 + d);
        if (poke) check("R10 restart ignored", l1c - prise, 4 + d);
    endtask

    task automatic run_gain(logic [7:0] w);
        int cs_len = 0, rises = 0, blen = 0;
        logic [7:0] got = '0;
        logic psclk = 1'b0;
        gain_word = w;
        gain_start = 1'b1;
        step();
        gain_start = 1'b0;
        for (int k = 1; k < 100; k++) begin
            if (!busy) break;
            blen++;
            if (!pot_cs_n) cs_len++;
            if (ser_clk && !psclk) begin
                rises++;
                got = {got[6:0], ser_dat};
            end
            psclk = ser_clk;
            step();
        end
        check("R7 pot frame length", cs_len, 4 * POT_W);
        check("R7 pot word", got, w);
        check("R7 sclk rises", rises, POT_W);
        check("R8 gain busy length", blen, 4 * POT_W);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (3) step();
        // R1 reset state
        check("R1 mode", mode_q, 0);
        check("R1 outs", {crate_l1, crate_l1_rst, test_pulse, ser_clk, busy}, 0);
        check("R1 frames", {dac_cs_n, pot_cs_n}, 2'b11);
        rst_n = 1'b1;
        step();

        // R3 trigger-follow pass-through
        for (int i = 0; i < 16; i++) begin
            ext_l1 = i[0] ^ i[2];
            ext_l1_rst = i[1];
            step();
            check("R3 l1 pass", crate_l1, i[0] ^ i[2]);
            check("R3 l1 reset pass", crate_l1_rst, i[1]);
        end
        ext_l1 = 1'b0;
        ext_l1_rst = 1'b0;
        step();

        // R2 mode writes while idle
        for (int m = 3; m >= 0; m--) begin
            set_mode(2'(m));
            check("R2 mode write", mode_q, m);
        end

        // R11 free-run quiet
        set_mode(2'd2);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            ext_l1 = 1'b1;
            ext_l1_rst = 1'b1;
            cal_start = i[0];
            gain_start = !i[0];
            step();
            if (crate_l1 || crate_l1_rst || test_pulse || !dac_cs_n || !pot_cs_n || busy) bad++;
        end
        ext_l1 = 1'b0; ext_l1_rst = 1'b0; cal_start = 1'b0; gain_start = 1'b0;
        step();
        check("R11 free-run quiet", bad, 0);

        // calibration sweep R4 R5 R6 R8
        set_mode(2'd1);
        for (int d = 0; d <= 16; d++) begin
            run_cal(16'(d * 16'h1357) ^ 16'hA5A5, d, 1'b0);
            step();
        end
        run_cal(16'hFFFF, 255, 1'b0);
        step();
        run_cal(16'h0000, 1, 1'b0);
        step();
        // R10 restart while busy ignored
        run_cal(16'h3C96, 4, 1'b1);
        step();

        // R10 gain start ignored in calibration mode
        gain_start = 1'b1;
        step();
        gain_start = 1'b0;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (!pot_cs_n || !dac_cs_n || busy || ser_clk) bad++;
            step();
        end
        check("R10 mismatched gain start", bad, 0);

        // R9 deferred mode write
        cal_delay = 8'd6;
        cal_start = 1'b1;
        step();
        cal_start = 1'b0;
        bad = 0;
        begin
            int k = 1;
            while (busy && k < 200) begin
                if (mode_q != 2'd1) bad++;
                mode_wr = (k == 10) || (k == 20);
                mode_wdata = (k == 10) ? 2'd3 : 2'd2;
                step();
                k++;
            end
            mode_wr = 1'b0;
            check("R9 busy length", k - 1, 91);
        end
        check("R9 mode held while busy", bad, 0);
        check("R9 mode at busy fall", mode_q, 1);
        step();
        check("R9 mode applied after", mode_q, 2);

        // R7 gain-trim sweep over every word
        set_mode(2'd3);
        for (int w = 0; w < 256; w++) begin
            run_gain(8'(w));
            step();
        end

        // R10 calibration start ignored in gain mode
        cal_start = 1'b1;
        step();
        cal_start = 1'b0;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (!dac_cs_n || busy || test_pulse) bad++;
            step();
        end
        check("R10 mismatched cal start", bad, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule